// File: doc/BRIEF.md
# Poison-Bit Tracker for Speculative Run-Ahead Retirement

This block keeps one poison flag per architectural register while the core runs ahead past a long-latency miss. Each cycle it receives at most one decoded micro-op in program order. It reports whether that micro-op may retire without execution and whether a branch needs a pipeline flush. It also updates the poison flags so that later consumers see which values are not real.

The load that started run-ahead completes at once, and its destination is poisoned. A poisoned source poisons every result computed from it. A result computed only from good values, such as a constant load, makes its destination good again. A branch that reads a poisoned register cannot be checked, so the predicted path is kept. A branch that reads only good registers is resolved normally. Outside run-ahead mode every flag is held clear and branches resolve as in normal operation.

All three outputs are registered. They appear in the cycle after the micro-op is presented.

Top module: `poison_tracker`

## Requirements
- R1: After reset, every poison flag is clear and the retire, skip and flush outputs are low.
- R2: In run-ahead mode, a valid micro-op of kind 0 (ALU/load) with the trigger flag set poisons its destination register from the next cycle and raises skip for that micro-op.
- R3: In run-ahead mode, a valid kind-0 micro-op poisons its destination if any source it uses is poisoned. A source is used only when its use flag is set.
- R4: Skip is high in the cycle after a valid micro-op exactly when run-ahead mode is on and the micro-op has a used poisoned source or is a trigger; otherwise skip is low.
- R5: Retire pulses in the cycle after each valid micro-op, once per micro-op and in presentation order. It is low after a cycle with no valid micro-op.
- R6: In run-ahead mode, a branch (kind 2) that uses a poisoned source never raises flush, whatever the predicted and actual directions.
- R7: A branch with no poisoned used source raises flush in the next cycle exactly when the predicted direction differs from the actual direction.
- R8: In run-ahead mode, a kind-1 (constant) micro-op, or a kind-0 micro-op that is not a trigger and has no poisoned used source, clears its destination's poison flag. Kinds 2 (branch) and 3 (no-op) write no register.
- R9: When run-ahead mode is low at a clock edge, all poison flags are clear after that edge. Triggers and poisoned sources then have no effect, and branches follow R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_mode | input | 1 | Run-ahead mode active |
| uop_valid | input | 1 | A micro-op is presented this cycle |
| uop_kind | input | 2 | 0 ALU/load, 1 constant, 2 branch, 3 no-op |
| use_a | input | 1 | First source is read |
| use_b | input | 1 | Second source is read |
| src_a | input | RIDX | First source register index |
| src_b | input | RIDX | Second source register index |
| dst | input | RIDX | Destination register index |
| trig_load | input | 1 | Micro-op is the load that started run-ahead |
| br_pred | input | 1 | Predicted branch direction |
| br_actual | input | 1 | Computed branch direction |
| inv_bits | output | NREG | Poison flag per register |
| retire | output | 1 | A micro-op retires |
| skip_exec | output | 1 | The retiring micro-op is not executed |
| flush_req | output | 1 | Misprediction flush request |

## Verification
The assertions assume that micro-ops arrive one per cycle in program order. They also assume the register indices stay inside the register count, and that ra_mode is a level that holds for whole cycles. The bench changes inputs only on the falling clock edge and uses indices from 0 to NREG-1. It sweeps every pair of source registers, with each combination of use flags and branch directions. Triggers and constant writes are mixed in so that the flags take many different patterns. The bench also toggles run-ahead mode between phases, so the entry and exit behaviour is covered.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    K_ALU   = 2'd0,
    K_CONST = 2'd1,
    K_BR    = 2'd2,
    K_NOP   = 2'd3
  } uop_kind_e;
endpackage

// File: rtl/pt_src_check.sv
module pt_src_check
  import pt_pkg::*;
#(
  parameter int NREG = 8,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic [NREG-1:0] inv_vec,
  input  logic            ra_mode,
  input  logic [1:0]      kind,
  input  logic            use_a,
  input  logic            use_b,
  input  logic [RIDX-1:0] src_a,
  input  logic [RIDX-1:0] src_b,
  input  logic            trig,
  output logic            src_inv,
  output logic            writes,
  output logic            is_br,
  output logic            trig_eff
);
  uop_kind_e k;
  logic      reads;

  always_comb begin
    k        = uop_kind_e'(kind);
    reads    = (k == K_ALU) || (k == K_BR);
    writes   = (k == K_ALU) || (k == K_CONST);
    is_br    = (k == K_BR);
    src_inv  = ra_mode && reads &&
               ((use_a && inv_vec[src_a]) || (use_b && inv_vec[src_b]));
    trig_eff = ra_mode && trig && (k == K_ALU);
  end
endmodule

// File: rtl/pt_inv_file.sv
module pt_inv_file #(
  parameter int NREG = 8,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ra_mode,
  input  logic            wr_en,
  input  logic [RIDX-1:0] wr_dst,
  input  logic            wr_inv,
  output logic [NREG-1:0] inv_q
);
  logic [NREG-1:0] inv_d;
  logic [NREG-1:0] inv_en;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    always_comb begin
      inv_en[g] = !ra_mode || (wr_en && (wr_dst == RIDX'(g)));
      inv_d[g]  = ra_mode ? wr_inv : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         inv_q[g] <= 1'b0;
      else if (inv_en[g]) inv_q[g] <= inv_d[g];
    end
  end

  a_r9_clear_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_mode |=> (inv_q == '0));
  a_r3_poison_written: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && wr_en && wr_inv) |=> inv_q[$past(wr_dst)]);
  a_r8_clean_written: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && wr_en && !wr_inv) |=> !inv_q[$past(wr_dst)]);
  a_r8_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode && !wr_en) |=> $stable(inv_q));
endmodule

// File: rtl/pt_retire.sv
module pt_retire (
  input  logic clk,
  input  logic rst_n,
  input  logic ra_mode,
  input  logic valid,
  input  logic is_br,
  input  logic src_inv,
  input  logic trig_eff,
  input  logic pred,
  input  logic actual,
  output logic retire_q,
  output logic skip_q,
  output logic flush_q
);
  logic retire_d, skip_d, flush_d;

  always_comb begin
    retire_d = valid;
    skip_d   = valid && ra_mode && (src_inv || trig_eff);
    flush_d  = valid && is_br && !src_inv && (pred != actual);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retire_q <= 1'b0;
      skip_q   <= 1'b0;
      flush_q  <= 1'b0;
    end else begin
      retire_q <= retire_d;
      skip_q   <= skip_d;
      flush_q  <= flush_d;
    end
  end

  a_r5_retire_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> retire_q);
  a_r5_no_idle_retire: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !retire_q);
  a_r6_poison_br_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && is_br && src_inv) |=> !flush_q);
  a_r4_skip_needs_runahead: assert property (@(posedge clk) disable iff (!rst_n)
    !ra_mode |=> !skip_q);
  a_r7_flush_only_branch: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && is_br) |=> !flush_q);
endmodule

// File: rtl/poison_tracker.sv
module poison_tracker #(
  parameter int NREG = 8,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ra_mode,
  input  logic            uop_valid,
  input  logic [1:0]      uop_kind,
  input  logic            use_a,
  input  logic            use_b,
  input  logic [RIDX-1:0] src_a,
  input  logic [RIDX-1:0] src_b,
  input  logic [RIDX-1:0] dst,
  input  logic            trig_load,
  input  logic            br_pred,
  input  logic            br_actual,
  output logic [NREG-1:0] inv_bits,
  output logic            retire,
  output logic            skip_exec,
  output logic            flush_req
);
  logic src_inv, writes, is_br, trig_eff;

  pt_src_check #(.NREG(NREG)) u_src (
    .inv_vec (inv_bits),
    .ra_mode (ra_mode),
    .kind    (uop_kind),
    .use_a   (use_a),
    .use_b   (use_b),
    .src_a   (src_a),
    .src_b   (src_b),
    .trig    (trig_load),
    .src_inv (src_inv),
    .writes  (writes),
    .is_br   (is_br),
    .trig_eff(trig_eff)
  );

  pt_inv_file #(.NREG(NREG)) u_inv (
    .clk   (clk),
    .rst_n (rst_n),
    .ra_mode(ra_mode),
    .wr_en (uop_valid && writes),
    .wr_dst(dst),
    .wr_inv(src_inv || trig_eff),
    .inv_q (inv_bits)
  );

  pt_retire u_ret (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_mode (ra_mode),
    .valid   (uop_valid),
    .is_br   (is_br),
    .src_inv (src_inv),
    .trig_eff(trig_eff),
    .pred    (br_pred),
    .actual  (br_actual),
    .retire_q(retire),
    .skip_q  (skip_exec),
    .flush_q (flush_req)
  );

  a_r2_trigger_poisons: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && ra_mode && trig_load && uop_kind == 2'd0) |=> (skip_exec && inv_bits[$past(dst)]));
endmodule

// File: tb/poison_tracker_tb.sv
module poison_tracker_tb_top;
  localparam int NREG = 8;
  localparam int RIDX = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n;
  logic ra_mode, uop_valid, use_a, use_b, trig_load, br_pred, br_actual;
  logic [1:0] uop_kind;
  logic [RIDX-1:0] src_a, src_b, dst;
  logic [NREG-1:0] inv_bits;
  logic retire, skip_exec, flush_req;

  int errors = 0;
  int checks = 0;
  bit model [NREG];

  always #2 clk = ~clk;

  poison_tracker #(.NREG(NREG)) dut_i (
    .clk(clk), .rst_n(rst_n), .ra_mode(ra_mode), .uop_valid(uop_valid),
    .uop_kind(uop_kind), .use_a(use_a), .use_b(use_b), .src_a(src_a),
    .src_b(src_b), .dst(dst), .trig_load(trig_load), .br_pred(br_pred),
    .br_actual(br_actual), .inv_bits(inv_bits), .retire(retire),
    .skip_exec(skip_exec), .flush_req(flush_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NREG-1:0] model_vec();
    logic [NREG-1:0] v;
    for (int i = 0; i < NREG; i++) v[i] = model[i];
    return v;
  endfunction

  // Drive one cycle at the falling edge, then check after the next falling edge.
  task automatic step(input bit ra, input bit vld, input int k, input bit ua, input bit ub,
                      input int sa, input int sb, input int dd, input bit trg,
                      input bit pr, input bit ac);
    bit si, te, wr, e_skip, e_flush;
    string tag;
    si = ra && (k == 0 || k == 2) && ((ua && model[sa]) || (ub && model[sb]));
    te = ra && trg && (k == 0);
    wr = (k == 0 || k == 1);
    e_skip  = vld && ra && (si || te);
    e_flush = vld && (k == 2) && !si && (pr != ac);
    ra_mode = ra; uop_valid = vld; uop_kind = 2'(k); use_a = ua; use_b = ub;
    src_a = RIDX'(sa); src_b = RIDX'(sb); dst = RIDX'(dd); trig_load = trg;
    br_pred = pr; br_actual = ac;
    if (!ra) begin
      for (int i = 0; i < NREG; i++) model[i] = 1'b0;
      tag = "R9";
    end else if (vld && wr) begin
      model[dd] = te || si;
      tag = te ? "R2" : (si ? "R3" : "R8");
    end else tag = "R8";
    @(negedge clk);
    chk(tag, 32'(inv_bits), 32'(model_vec()));
    chk("R5", 32'(retire), 32'(vld));
    chk(te ? "R2" : "R4", 32'(skip_exec), 32'(e_skip));
    chk(si ? "R6" : "R7", 32'(flush_req), 32'(e_flush));
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 1'b0;
    rst_n = 1'b0; ra_mode = 0; uop_valid = 0; uop_kind = 0; use_a = 0; use_b = 0;
    src_a = 0; src_b = 0; dst = 0; trig_load = 0; br_pred = 0; br_actual = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", 32'(inv_bits), 32'h0);
    chk("R1", 32'(retire), 32'h0);
    chk("R1", 32'(skip_exec), 32'h0);
    chk("R1", 32'(flush_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Normal mode: triggers ignored, branches resolve normally (R9, R7)
    for (int p = 0; p < 4; p++) begin
      step(0, 1, 0, 1, 1, p, p + 1, p, 1, 0, 0);
      step(0, 1, 2, 1, 1, p, p + 2, 0, 0, p[0], p[1]);
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // Run-ahead: trigger load poisons r3 (R2)
    step(1, 1, 0, 1, 0, 1, 0, 3, 1, 0, 0);
    // Exhaustive source sweep with reseeding
    for (int a = 0; a < NREG; a++) begin
      step(1, 1, 0, 0, 0, 0, 0, a, 1, 0, 0);
      step(1, 1, 1, 1, 1, a, a, (a + 4) % NREG, 0, 0, 0);
      for (int b = 0; b < NREG; b++) begin
        for (int u = 0; u < 4; u++) begin
          for (int d = 0; d < 4; d++)
            step(1, 1, 2, u[0], u[1], a, b, 0, 0, d[0], d[1]);
          step(1, 1, 0, u[0], u[1], a, b, (a + b + u) % NREG, 0, 0, 0);
          step(1, 1, 3, u[0], u[1], a, b, b, 1, 0, 1);
        end
        step(1, 0, 0, 1, 1, a, b, b, 1, 1, 0);
      end
    end
    // Poison everything, then exit (R9)
    for (int r = 0; r < NREG; r++) step(1, 1, 0, 0, 0, 0, 0, r, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int d = 0; d < 4; d++) step(0, 1, 2, 1, 1, 0, 7, 0, 0, d[0], d[1]);
    // Re-enter: flags start clear, constant write keeps clean (R8)
    step(1, 1, 1, 0, 0, 0, 0, 2, 0, 0, 0);
    step(1, 1, 2, 1, 1, 2, 5, 0, 0, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule